// File: doc/BRIEF.md
# DRAM Address Multiplexer with Capacity-Based Bus Error

This block connects a 16-bit CPU bus that uses byte addresses to two rows of DRAM modules, each row a pair of 8-bit modules forming one 16-bit word. For an access that falls in the RAM window, the low 4 MB of the 24-bit space, it drives the row half and then the column half of the word address onto a shared 10-bit DRAM address bus. It also selects one of the two rows and runs the RAS, CAS and DTACK strobes from a 16 MHz clock enable.

Three static strap inputs give the installed memory. One strap selects the module density (256K or 1M words), one says whether a second row is fitted, and one picks a mixed fit of a 1M row plus a 256K row. From these the block works out the fitted capacity. Any access in the window beyond that capacity ends in a bus error and no DRAM cycle is run, so the access does not wrap onto real memory.

Top module: `dram_addr_mux`

## Requirements
- R1: While rst_n is low at a clock edge, and after it, with no access: ras_n=2'b11, ucas_n=lcas_n=dtack_n=berr_n=1, dram_addr=0.
- R2: The capacity limits are 512 KB (small modules, one row), 1 MB (small, two rows), 2 MB (large, one row), 4 MB (large, two rows) and 2.5 MB (mixed). The byte address just below the limit runs a DRAM cycle. The limit address itself ends in a bus error.
- R3: For an in-window access at or above the limit, berr_n goes low on the first enabled edge that samples as_n low. It stays low until an enabled edge samples as_n high. No RAS, no CAS and no DTACK are driven for that access.
- R4: A valid access runs in this order, one enabled edge per step: row address with RAS of the selected row; column address; CAS; dtack_n low. All strobes hold until an enabled edge samples as_n high, and then all return high.
- R5: The word address is w[k] = cpu_addr[k+1]. On a row built from large modules, row = w[19:10] and column = w[9:0]. On a row built from small modules, row = {0, w[17:9]} and column = {0, w[8:0]}.
- R6: dram_addr[9] stays 0 in both phases unless the selected row is built from large modules. In the mixed fit, row 1 is the small row.
- R7: ras_n[0] drives row 0 and ras_n[1] drives row 1. With one row, row 0 is always used. With two small rows, row 1 is selected by w[18]. With two large rows or the mixed fit, row 1 is selected by w[20].
- R8: strap_mixed has no effect unless strap_big and strap_two_rows are both 1.
- R9: An access with cpu_addr[23:22] != 0 produces no strobe, no DTACK and no bus error.
- R10: The sequence advances only on edges where clk_en is 1. The outputs hold between such edges.
- R11: ucas_n goes low only if uds_n is low, and lcas_n goes low only if lds_n is low, in the CAS and DTACK steps.
- R12: If as_n is seen high on an enabled edge in the middle of the sequence, all strobes return high from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en | input | 1 | 16 MHz step enable |
| strap_big | input | 1 | 1 = 1M-word modules fitted |
| strap_two_rows | input | 1 | 1 = both rows fitted |
| strap_mixed | input | 1 | 1 = row 0 large, row 1 small (needs both other straps) |
| cpu_addr | input | 23 | CPU byte address bits 23..1 |
| as_n | input | 1 | Address strobe, active low |
| uds_n | input | 1 | Upper byte strobe, active low |
| lds_n | input | 1 | Lower byte strobe, active low |
| dram_addr | output | 10 | Multiplexed DRAM address |
| ras_n | output | 2 | Row strobe per row, active low |
| ucas_n | output | 1 | Upper byte column strobe, active low |
| lcas_n | output | 1 | Lower byte column strobe, active low |
| dtack_n | output | 1 | Transfer acknowledge, active low |
| berr_n | output | 1 | Bus error, active low |

## Verification
The hardest case to reach is the mixed fit. Here the selected row changes density in the middle of the address space. A row-1 access must therefore switch to the narrow split and hold dram_addr[9] low, while row 0 at the addresses just below still uses the wide split. The stimulus table sets all three straps and walks the last valid word of each row and the first word past the 2.5 MB limit. It also repeats the same addresses with strap_mixed set but one of the other straps clear, which shows that the third strap is ignored in those cases.

// File: rtl/dram_mux_pkg.sv
// Shared types for the DRAM address multiplexer.
// Assumes: the sequencer states and the strap-derived memory fit are the only
// values shared between modules.
package dram_mux_pkg;

    // Access sequencer states, one per enabled step.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_CAS,
        ST_ACK,
        ST_ERR
    } seq_state_t;

    // Installed memory fit, decoded from the three straps.
    typedef enum logic [2:0] {
        FIT_SMALL_ONE,
        FIT_SMALL_TWO,
        FIT_BIG_ONE,
        FIT_BIG_TWO,
        FIT_MIXED
    } mem_fit_t;

endpackage

// File: rtl/dram_cap_decode.sv
// Capacity and row-select decode.
// Works out the installed fit from the straps. From the upper word-address
// bits it then says whether the access is inside the fitted capacity, which
// row it targets, and whether that row is built from large modules.
// Assumes: the straps are static; hi_bits are word bits [WORD_W-1:SMALL_W],
// so bit 0 is the first bit above one small row.
module dram_cap_decode
    import dram_mux_pkg::*;
#(
    parameter int SMALL_HALF = 9,
    parameter int BIG_HALF   = 10
) (
    input  logic                                    strap_big,
    input  logic                                    strap_two_rows,
    input  logic                                    strap_mixed,
    input  logic [2*BIG_HALF-2*SMALL_HALF:0]        hi_bits,
    output logic                                    in_range,
    output logic                                    row_sel,
    output logic                                    row_big
);
    localparam int HI_W = 2*BIG_HALF - 2*SMALL_HALF + 1;

    mem_fit_t fit;

    // Pick the fit; the mixed strap counts only with both other straps set.
    always_comb begin
        if (strap_big && strap_two_rows && strap_mixed) fit = FIT_MIXED;
        else if (strap_big && strap_two_rows)           fit = FIT_BIG_TWO;
        else if (strap_big)                             fit = FIT_BIG_ONE;
        else if (strap_two_rows)                        fit = FIT_SMALL_TWO;
        else                                            fit = FIT_SMALL_ONE;
    end

    // Range check and row select for each fit.
    always_comb begin
        in_range = 1'b0;
        row_sel  = 1'b0;
        unique case (fit)
            FIT_SMALL_ONE: begin
                in_range = (hi_bits == '0);
                row_sel  = 1'b0;
            end
            FIT_SMALL_TWO: begin
                in_range = (hi_bits[HI_W-1:1] == '0);
                row_sel  = hi_bits[0];
            end
            FIT_BIG_ONE: begin
                in_range = !hi_bits[HI_W-1];
                row_sel  = 1'b0;
            end
            FIT_BIG_TWO: begin
                in_range = 1'b1;
                row_sel  = hi_bits[HI_W-1];
            end
            FIT_MIXED: begin
                in_range = !hi_bits[HI_W-1] || (hi_bits[HI_W-2:0] == '0);
                row_sel  = hi_bits[HI_W-1];
            end
            default: begin
                in_range = 1'b0;
                row_sel  = 1'b0;
            end
        endcase
    end

    // Density of the selected row: in the mixed fit row 1 is the small one.
    always_comb begin
        row_big = strap_big && !(fit == FIT_MIXED && row_sel);
    end

endmodule

// File: rtl/dram_addr_split.sv
// Row/column split of a latched word address.
// A large-module row takes BIG_HALF bits per half. A small-module row takes
// SMALL_HALF bits per half, and the unused top lines are held at zero.
// Assumes: BIG_HALF > SMALL_HALF.
module dram_addr_split #(
    parameter int SMALL_HALF = 9,
    parameter int BIG_HALF   = 10
) (
    input  logic [2*BIG_HALF-1:0] word,
    input  logic                  row_big,
    output logic [BIG_HALF-1:0]   row_addr,
    output logic [BIG_HALF-1:0]   col_addr
);
    localparam int PAD_W = BIG_HALF - SMALL_HALF;

    // Choose the split that matches the selected row's density.
    always_comb begin
        if (row_big) begin
            row_addr = word[2*BIG_HALF-1:BIG_HALF];
            col_addr = word[BIG_HALF-1:0];
        end else begin
            row_addr = {{PAD_W{1'b0}}, word[2*SMALL_HALF-1:SMALL_HALF]};
            col_addr = {{PAD_W{1'b0}}, word[SMALL_HALF-1:0]};
        end
    end

endmodule

// File: rtl/dram_access_seq.sv
// Access sequencer.
// Steps once per enabled clock. A valid access goes row, column, CAS and then
// acknowledge. An out-of-range access goes to a bus-error hold. Every busy
// state drops back to idle once the address strobe is seen high.
// Assumes: hit and ok are stable while as_n is low.
module dram_access_seq
    import dram_mux_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clk_en,
    input  logic       as_n,
    input  logic       uds_n,
    input  logic       lds_n,
    input  logic       hit,
    input  logic       ok,
    input  logic       row_q,
    output logic       load,
    output logic       col_phase,
    output logic [1:0] ras_n,
    output logic       ucas_n,
    output logic       lcas_n,
    output logic       dtack_n,
    output logic       berr_n
);
    seq_state_t state, state_nx;

    // Capture pulse for the address latch at the start of a valid access.
    always_comb begin
        load = clk_en && (state == ST_IDLE) && !as_n && hit && ok;
    end

    // Next-state rule.
    always_comb begin
        state_nx = state;
        if (as_n) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: if (hit) state_nx = ok ? ST_ROW : ST_ERR;
                ST_ROW:  state_nx = ST_COL;
                ST_COL:  state_nx = ST_CAS;
                ST_CAS:  state_nx = ST_ACK;
                ST_ACK:  state_nx = ST_ACK;
                ST_ERR:  state_nx = ST_ERR;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // State register, stepped only on enabled clocks.
    always_ff @(posedge clk) begin
        if (!rst_n)      state <= ST_IDLE;
        else if (clk_en) state <= state_nx;
    end

    // Strobe decode from the current state.
    always_comb begin
        logic ras_on, cas_on;
        ras_on    = (state == ST_ROW) || (state == ST_COL) ||
                    (state == ST_CAS) || (state == ST_ACK);
        cas_on    = (state == ST_CAS) || (state == ST_ACK);
        col_phase = (state == ST_COL) || cas_on;
        ras_n     = 2'b11;
        if (ras_on) ras_n[row_q] = 1'b0;
        ucas_n    = !(cas_on && !uds_n);
        lcas_n    = !(cas_on && !lds_n);
        dtack_n   = (state != ST_ACK);
        berr_n    = (state != ST_ERR);
    end

endmodule

// File: rtl/dram_addr_mux.sv
// DRAM address multiplexer top.
// Decodes the RAM window and the capacity, latches the word address at the
// start of each access and puts the row or column half on the DRAM address.
// Assumes: the straps are static while an access is in progress; two rows.
module dram_addr_mux
    import dram_mux_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int SMALL_HALF = 9,
    parameter int BIG_HALF   = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clk_en,
    input  logic                strap_big,
    input  logic                strap_two_rows,
    input  logic                strap_mixed,
    input  logic [ADDR_W-1:1]   cpu_addr,
    input  logic                as_n,
    input  logic                uds_n,
    input  logic                lds_n,
    output logic [BIG_HALF-1:0] dram_addr,
    output logic [1:0]          ras_n,
    output logic                ucas_n,
    output logic                lcas_n,
    output logic                dtack_n,
    output logic                berr_n
);
    localparam int BIG_W   = 2*BIG_HALF;
    localparam int SMALL_W = 2*SMALL_HALF;
    localparam int WORD_W  = BIG_W + 1;

    logic [WORD_W-1:0]     word;
    logic                  hit, ok, row_sel, row_big;
    logic                  load, col_phase;
    logic [BIG_W-1:0]      word_q;
    logic                  row_q, big_q;
    logic [BIG_HALF-1:0]   row_addr, col_addr;

    // Word address and RAM window hit.
    always_comb begin
        word = cpu_addr[WORD_W:1];
        hit  = (cpu_addr[ADDR_W-1:WORD_W+1] == '0);
    end

    dram_cap_decode #(
        .SMALL_HALF (SMALL_HALF),
        .BIG_HALF   (BIG_HALF)
    ) u_cap (
        .strap_big      (strap_big),
        .strap_two_rows (strap_two_rows),
        .strap_mixed    (strap_mixed),
        .hi_bits        (word[WORD_W-1:SMALL_W]),
        .in_range       (ok),
        .row_sel        (row_sel),
        .row_big        (row_big)
    );

    // Latch the address, row and density for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            row_q  <= 1'b0;
            big_q  <= 1'b0;
        end else if (load) begin
            word_q <= word[BIG_W-1:0];
            row_q  <= row_sel;
            big_q  <= row_big;
        end
    end

    dram_addr_split #(
        .SMALL_HALF (SMALL_HALF),
        .BIG_HALF   (BIG_HALF)
    ) u_split (
        .word     (word_q),
        .row_big  (big_q),
        .row_addr (row_addr),
        .col_addr (col_addr)
    );

    dram_access_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .as_n      (as_n),
        .uds_n     (uds_n),
        .lds_n     (lds_n),
        .hit       (hit),
        .ok        (ok),
        .row_q     (row_q),
        .load      (load),
        .col_phase (col_phase),
        .ras_n     (ras_n),
        .ucas_n    (ucas_n),
        .lcas_n    (lcas_n),
        .dtack_n   (dtack_n),
        .berr_n    (berr_n)
    );

    // Address phase mux.
    always_comb begin
        dram_addr = col_phase ? col_addr : row_addr;
    end

endmodule

// File: rtl/dram_addr_mux_chk.sv
// Port-level assertion checker for dram_addr_mux, attached by bind.
module dram_addr_mux_chk #(
    parameter int BIG_HALF = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic                clk_en,
    input logic                strap_big,
    input logic                strap_two_rows,
    input logic                strap_mixed,
    input logic                as_n,
    input logic [BIG_HALF-1:0] dram_addr,
    input logic [1:0]          ras_n,
    input logic                ucas_n,
    input logic                lcas_n,
    input logic                dtack_n,
    input logic                berr_n
);
    AST_ERR_NO_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        !berr_n |-> (ras_n == 2'b11 && ucas_n && lcas_n)); // R3
    AST_ERR_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !(!berr_n && !dtack_n)); // R3
    AST_ERR_NEEDS_AS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(berr_n) |-> !as_n); // R3
    AST_ONE_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ras_n)); // R7
    AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ucas_n || !lcas_n) |-> (ras_n != 2'b11)); // R4
    AST_ACK_AFTER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dtack_n) |-> $past(ras_n != 2'b11)); // R4
    AST_SMALL_RA_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!strap_big && ras_n != 2'b11) |-> !dram_addr[BIG_HALF-1]); // R6
    AST_MIXED_ROW1_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (strap_big && strap_two_rows && strap_mixed && !ras_n[1])
            |-> !dram_addr[BIG_HALF-1]); // R6
    AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(ras_n) && $stable(dtack_n) &&
                     $stable(berr_n) && $stable(dram_addr))); // R10
endmodule

bind dram_addr_mux dram_addr_mux_chk #(.BIG_HALF(BIG_HALF)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .clk_en         (clk_en),
    .strap_big      (strap_big),
    .strap_two_rows (strap_two_rows),
    .strap_mixed    (strap_mixed),
    .as_n           (as_n),
    .dram_addr      (dram_addr),
    .ras_n          (ras_n),
    .ucas_n         (ucas_n),
    .lcas_n         (lcas_n),
    .dtack_n        (dtack_n),
    .berr_n         (berr_n)
);

// File: tb/dram_addr_mux_tb.sv
module dram_addr_mux_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        big;
        logic        two;
        logic        mix;
        logic [23:0] addr;
        logic [1:0]  kind;   // 0 valid, 1 bus error, 2 no response
        logic        row;
        logic [9:0]  ra_r;
        logic [9:0]  ra_c;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b0,24'h07FFFE,2'd0,1'b0,10'h1FF,10'h1FF}, // R2 R5 small one last
        '{1'b0,1'b0,1'b0,24'h080000,2'd1,1'b0,10'h000,10'h000}, // R2 small one limit
        '{1'b0,1'b0,1'b0,24'h02468A,2'd0,1'b0,10'h091,10'h145}, // R5 small split
        '{1'b0,1'b1,1'b0,24'h0FFFFE,2'd0,1'b1,10'h1FF,10'h1FF}, // R2 R7 small two last
        '{1'b0,1'b1,1'b0,24'h100000,2'd1,1'b0,10'h000,10'h000}, // R2 small two limit
        '{1'b0,1'b1,1'b0,24'h080000,2'd0,1'b1,10'h000,10'h000}, // R7 row1 first
        '{1'b0,1'b1,1'b0,24'h07FFFE,2'd0,1'b0,10'h1FF,10'h1FF}, // R7 row0 last
        '{1'b1,1'b0,1'b0,24'h1FFFFE,2'd0,1'b0,10'h3FF,10'h3FF}, // R2 big one last
        '{1'b1,1'b0,1'b0,24'h200000,2'd1,1'b0,10'h000,10'h000}, // R2 big one limit
        '{1'b1,1'b0,1'b0,24'h155554,2'd0,1'b0,10'h2AA,10'h2AA}, // R5 R6 big split
        '{1'b1,1'b1,1'b0,24'h3FFFFE,2'd0,1'b1,10'h3FF,10'h3FF}, // R2 big two last
        '{1'b1,1'b1,1'b0,24'h2AAAAA,2'd0,1'b1,10'h155,10'h155}, // R7 big two row1
        '{1'b1,1'b1,1'b0,24'h400000,2'd2,1'b0,10'h000,10'h000}, // R9 outside window
        '{1'b1,1'b1,1'b1,24'h27FFFE,2'd0,1'b1,10'h1FF,10'h1FF}, // R2 R6 mixed row1 last
        '{1'b1,1'b1,1'b1,24'h280000,2'd1,1'b0,10'h000,10'h000}, // R2 mixed limit
        '{1'b1,1'b1,1'b1,24'h1FFFFE,2'd0,1'b0,10'h3FF,10'h3FF}, // R6 mixed row0 last
        '{1'b1,1'b0,1'b1,24'h200000,2'd1,1'b0,10'h000,10'h000}, // R8 mixed w/o two rows
        '{1'b0,1'b1,1'b1,24'h100000,2'd1,1'b0,10'h000,10'h000}, // R8 mixed w/o big
        '{1'b0,1'b0,1'b0,24'hFFFFFE,2'd2,1'b0,10'h000,10'h000}  // R9 top of space
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b0;
    logic        strap_big = 1'b0, strap_two_rows = 1'b0, strap_mixed = 1'b0;
    logic [23:1] cpu_addr = '0;
    logic        as_n = 1'b1, uds_n = 1'b1, lds_n = 1'b1;
    logic [9:0]  dram_addr;
    logic [1:0]  ras_n;
    logic        ucas_n, lcas_n, dtack_n, berr_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_addr_mux u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .clk_en         (clk_en),
        .strap_big      (strap_big),
        .strap_two_rows (strap_two_rows),
        .strap_mixed    (strap_mixed),
        .cpu_addr       (cpu_addr),
        .as_n           (as_n),
        .uds_n          (uds_n),
        .lds_n          (lds_n),
        .dram_addr      (dram_addr),
        .ras_n          (ras_n),
        .ucas_n         (ucas_n),
        .lcas_n         (lcas_n),
        .dtack_n        (dtack_n),
        .berr_n         (berr_n)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_bus(input string req);
        check(req, "ras_n idle", 32'(ras_n), 32'h3);
        check(req, "cas idle", 32'({ucas_n, lcas_n}), 32'h3);
        check(req, "dtack/berr idle", 32'({dtack_n, berr_n}), 32'h3);
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        string tag;
        tag = $sformatf("R2/R5/R7 vec%0d", idx);
        strap_big = v.big; strap_two_rows = v.two; strap_mixed = v.mix;
        cpu_addr = v.addr[23:1]; uds_n = 1'b0; lds_n = 1'b0; as_n = 1'b0;
        step();
        if (v.kind == 2'd0) begin
            check(tag, "R4 row step ras_n", 32'(ras_n), v.row ? 32'h1 : 32'h2);
            check(tag, "R5 row address", 32'(dram_addr), 32'(v.ra_r));
            check(tag, "no berr", 32'(berr_n), 32'h1);
            step();
            check(tag, "R5 column address", 32'(dram_addr), 32'(v.ra_c));
            check(tag, "R4 no cas yet", 32'({ucas_n, lcas_n}), 32'h3);
            step();
            check(tag, "R4 cas step", 32'({ucas_n, lcas_n}), 32'h0);
            check(tag, "R4 no ack yet", 32'(dtack_n), 32'h1);
            step();
            check(tag, "R4 ack", 32'(dtack_n), 32'h0);
            step();
            check(tag, "R4 hold", 32'({ras_n, dtack_n}), v.row ? 32'h2 : 32'h4);
        end else if (v.kind == 2'd1) begin
            check("R3", "berr asserted", 32'(berr_n), 32'h0);
            check("R3", "no ras on error", 32'(ras_n), 32'h3);
            step(); step(); step();
            check("R3", "berr held", 32'(berr_n), 32'h0);
            check("R3", "no ack on error", 32'({dtack_n, ucas_n, lcas_n}), 32'h7);
        end else begin
            step(); step(); step();
            idle_bus("R9");
        end
        as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1;
        step();
        idle_bus("R4/R3 release");
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        @(negedge clk); @(negedge clk); @(negedge clk);
        idle_bus("R1");
        check("R1", "dram_addr reset", 32'(dram_addr), 32'h0);
        rst_n = 1'b1; clk_en = 1'b1;
        step();
        idle_bus("R1");

        // Table walk over strap combinations and boundary words
        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // R11: single byte strobes
        strap_big = 1'b1; strap_two_rows = 1'b0; strap_mixed = 1'b0;
        cpu_addr = 23'h000100; uds_n = 1'b0; lds_n = 1'b1; as_n = 1'b0;
        step(); step(); step();
        check("R11", "upper only", 32'({ucas_n, lcas_n}), 32'h1);
        as_n = 1'b1; uds_n = 1'b1; step();
        uds_n = 1'b1; lds_n = 1'b0; as_n = 1'b0;
        step(); step(); step(); step();
        check("R11", "lower only", 32'({ucas_n, lcas_n}), 32'h2);
        as_n = 1'b1; lds_n = 1'b1; step();

        // R10: no progress while clk_en is low
        clk_en = 1'b0;
        cpu_addr = 23'h0AAAAA; uds_n = 1'b0; lds_n = 1'b0; as_n = 1'b0;
        step(); step(); step();
        check("R10", "no ras without enable", 32'(ras_n), 32'h3);
        clk_en = 1'b1; step(); clk_en = 1'b0;
        check("R10", "ras after one enable", 32'(ras_n), 32'h2);
        step(); step();
        check("R10", "row phase held", 32'(dram_addr), 32'h2AA);
        check("R10", "ras held", 32'(ras_n), 32'h2);
        clk_en = 1'b1; step();
        check("R10", "column after enable", 32'(dram_addr), 32'h2AA);
        as_n = 1'b1; step();

        // R12: address strobe negated mid-sequence
        cpu_addr = 23'h000010; as_n = 1'b0;
        step(); step();
        check("R12", "in column step", 32'(ras_n), 32'h2);
        as_n = 1'b1;
        step();
        idle_bus("R12");
        step();
        idle_bus("R12");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule